// File: doc/BRIEF.md
# Execution Mode Switch Controller

This block decides, frame by frame, whether the core leaves out-of-order mode to run a prebuilt static-schedule frame, and when it falls back to out-of-order mode. It is fed by the frame table lookup: a hit arrives with the frame's id, op count and lane width, plus three table bits: present, friendly, and trained (IPC history exists). It also receives the current ROB occupancy, a pulse when the last word of the running frame commits together with the out-of-order and static IPC measured for that frame, and three rollback causes: control-flow mismatch, memory-ordering conflict and exception.

In static mode the controller holds the running frame and at most one queued successor, so frames can follow back-to-back. On each commit it compares the two IPC figures without division and asks the frame table either to promote the frame (set friendly) or to demote it. A rollback demotes the running frame, drops any queued successor and pulses a restart so fetch resumes in out-of-order mode at the frame start. The controller also drives a power enable per functional-unit lane: it widens at once when a wider frame is accepted and narrows only when the previous frame commits.

Top module: `mode_switch_ctrl`

## Requirements
- R1: A lookup is accepted only when valid and present, and either friendly or untrained (trained=0); a trained unfriendly or an absent frame is refused.
- R2: Entry into static mode and queueing are refused when 2*rob_occ_i > ROB_DEPTH (128); occupancy of exactly 64 is allowed.
- R3: From out-of-order mode a frame needs at least MIN_OPS (64) ops; in static mode a frame of any op count may be queued.
- R4: In static mode one successor may be queued; while the slot is full further lookups are refused; on commit the queued frame becomes current in the same cycle, and a lookup in that commit cycle may refill the slot. A commit with nothing queued and no accepted lookup returns to out-of-order mode.
- R5: On commit, the frame is promoted if 10*static_ipc_i >= 9*ooo_ipc_i, else demoted; promote_o or demote_o pulses one cycle later with evt_id_o set to that frame's id, never both.
- R6: Any rollback cause in static mode returns to out-of-order mode in the next cycle, pulses restart_o and demote_o for the running frame, and discards the queued successor; rollback wins over a same-cycle commit. Rollback and commit inputs are ignored in out-of-order mode.
- R7: Accepting a frame wider than the current lane count raises the lane count in the next cycle; on entry from out-of-order mode the count becomes the frame width. A width of 0 counts as 1 and above 6 as 6.
- R8: The lane count in static mode never drops except on a commit, where it becomes the new current frame's width (or the larger queued width).
- R9: On any return to out-of-order mode the lane count is OOO_LANES (4).
- R10: lane_en_o bit i is 1 exactly when i < lane count, so the mask is contiguous from bit 0.
- R11: After reset the block is in out-of-order mode with lanes 0..3 on and no pulse active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lookup_valid_i | input | 1 | Frame table hit for the predicted target |
| lookup_present_i | input | 1 | Frame is installed in the frame cache |
| lookup_friendly_i | input | 1 | Frame is marked friendly |
| lookup_trained_i | input | 1 | Frame has IPC history |
| lookup_id_i | input | 4 | Frame id |
| lookup_ops_i | input | 9 | Frame op count |
| lookup_width_i | input | 3 | Frame lane width |
| rob_occ_i | input | 8 | ROB occupancy |
| frame_done_i | input | 1 | Last word of the running frame commits |
| ooo_ipc_i | input | 8 | Out-of-order IPC of the committing frame |
| static_ipc_i | input | 8 | Static-mode IPC of the committing frame |
| ctrl_mismatch_i | input | 1 | Rollback: control-flow mismatch |
| mem_conflict_i | input | 1 | Rollback: memory-ordering conflict |
| exception_i | input | 1 | Rollback: exception |
| static_mode_o | output | 1 | 1 in static-schedule mode |
| lane_en_o | output | 6 | Per-lane power enable |
| demote_o | output | 1 | Demote request pulse |
| promote_o | output | 1 | Set-friendly request pulse |
| evt_id_o | output | 4 | Frame id of the demote/promote request |
| restart_o | output | 1 | Resume out-of-order at frame start |

## Verification
Two functions meet in one cycle here: the commit of the running frame and the lookup of its successor, and the commit and a rollback. The bench drives commit and lookup together with the slot both empty and full, and drives a rollback in the same cycle as a commit, and a cycle-accurate model in the bench decides which frame becomes current, the lane count, and whether a promote, demote or restart follows. Random traffic then mixes these collisions with every refusal reason.

// File: rtl/msw_pkg.sv
package msw_pkg;
  typedef enum logic {MODE_OOO = 1'b0, MODE_STATIC = 1'b1} mode_e;
endpackage

// File: rtl/msw_entry_gate.sv
module msw_entry_gate #(
  parameter int NUM_LANES  = 6,
  parameter int ROB_DEPTH  = 128,
  parameter int MIN_OPS    = 64,
  parameter int OPS_W      = 9,
  localparam int ROB_W     = $clog2(ROB_DEPTH + 1),
  localparam int WIDTH_W   = $clog2(NUM_LANES + 1)
) (
  input  logic               static_i,
  input  logic               slot_free_i,
  input  logic               valid_i,
  input  logic               present_i,
  input  logic               friendly_i,
  input  logic               trained_i,
  input  logic [OPS_W-1:0]   ops_i,
  input  logic [WIDTH_W-1:0] width_i,
  input  logic [ROB_W-1:0]   rob_occ_i,
  output logic               accept_o,
  output logic [WIDTH_W-1:0] width_o
);
  logic rob_ok, table_ok, size_ok;

  assign rob_ok   = ({1'b0, rob_occ_i} << 1) <= (ROB_W+1)'(ROB_DEPTH);
  assign table_ok = valid_i && present_i && (friendly_i || !trained_i);
  assign size_ok  = static_i ? slot_free_i : (ops_i >= OPS_W'(MIN_OPS));
  assign accept_o = table_ok && rob_ok && size_ok;

  always_comb begin
    if (width_i == '0)                          width_o = WIDTH_W'(1);
    else if (width_i > WIDTH_W'(NUM_LANES))     width_o = WIDTH_W'(NUM_LANES);
    else                                        width_o = width_i;
  end
endmodule

// File: rtl/msw_ipc_judge.sv
module msw_ipc_judge #(
  parameter int IPC_W = 8
) (
  input  logic [IPC_W-1:0] ooo_ipc_i,
  input  logic [IPC_W-1:0] static_ipc_i,
  output logic             ok_o
);
  localparam int PROD_W = IPC_W + 4;
  logic [PROD_W-1:0] s_scaled, o_scaled;

  // static IPC within 10% of out-of-order IPC
  assign s_scaled = PROD_W'(static_ipc_i) * PROD_W'(10);
  assign o_scaled = PROD_W'(ooo_ipc_i) * PROD_W'(9);
  assign ok_o     = s_scaled >= o_scaled;
endmodule

// File: rtl/msw_lane_ctrl.sv
module msw_lane_ctrl #(
  parameter int NUM_LANES = 6,
  parameter int OOO_LANES = 4,
  localparam int WIDTH_W  = $clog2(NUM_LANES + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [WIDTH_W-1:0]   lane_nxt_i,
  output logic [WIDTH_W-1:0]   lane_cnt_o,
  output logic [NUM_LANES-1:0] lane_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lane_cnt_o <= WIDTH_W'(OOO_LANES);
    else         lane_cnt_o <= lane_nxt_i;
  end

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign lane_en_o[i] = lane_cnt_o > WIDTH_W'(i);
  end
endmodule

// File: rtl/mode_switch_ctrl.sv
module mode_switch_ctrl #(
  parameter int NUM_LANES = 6,
  parameter int OOO_LANES = 4,
  parameter int ROB_DEPTH = 128,
  parameter int MIN_OPS   = 64,
  parameter int OPS_W     = 9,
  parameter int IPC_W     = 8,
  parameter int ID_W      = 4,
  localparam int ROB_W    = $clog2(ROB_DEPTH + 1),
  localparam int WIDTH_W  = $clog2(NUM_LANES + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 lookup_valid_i,
  input  logic                 lookup_present_i,
  input  logic                 lookup_friendly_i,
  input  logic                 lookup_trained_i,
  input  logic [ID_W-1:0]      lookup_id_i,
  input  logic [OPS_W-1:0]     lookup_ops_i,
  input  logic [WIDTH_W-1:0]   lookup_width_i,
  input  logic [ROB_W-1:0]     rob_occ_i,
  input  logic                 frame_done_i,
  input  logic [IPC_W-1:0]     ooo_ipc_i,
  input  logic [IPC_W-1:0]     static_ipc_i,
  input  logic                 ctrl_mismatch_i,
  input  logic                 mem_conflict_i,
  input  logic                 exception_i,
  output logic                 static_mode_o,
  output logic [NUM_LANES-1:0] lane_en_o,
  output logic                 demote_o,
  output logic                 promote_o,
  output logic [ID_W-1:0]      evt_id_o,
  output logic                 restart_o
);
  import msw_pkg::*;

  mode_e              mode_q, mode_d;
  logic [ID_W-1:0]    cur_q, cur_d, nid_q, nid_d, evt_d;
  logic [WIDTH_W-1:0] nw_q, nw_d, lane_cnt, lane_d, acc_w;
  logic               nv_q, nv_d, dem_d, pro_d, rs_d;
  logic               in_static, rb_any, rb, done, accept, ipc_ok;

  assign in_static = (mode_q == MODE_STATIC);
  assign rb_any    = ctrl_mismatch_i || mem_conflict_i || exception_i;
  assign rb        = in_static && rb_any;
  assign done      = in_static && frame_done_i && !rb_any;

  msw_entry_gate #(
    .NUM_LANES(NUM_LANES), .ROB_DEPTH(ROB_DEPTH), .MIN_OPS(MIN_OPS), .OPS_W(OPS_W)
  ) u_gate (
    .static_i   (in_static),
    .slot_free_i(!nv_q || frame_done_i),
    .valid_i    (lookup_valid_i),
    .present_i  (lookup_present_i),
    .friendly_i (lookup_friendly_i),
    .trained_i  (lookup_trained_i),
    .ops_i      (lookup_ops_i),
    .width_i    (lookup_width_i),
    .rob_occ_i  (rob_occ_i),
    .accept_o   (accept),
    .width_o    (acc_w)
  );

  msw_ipc_judge #(.IPC_W(IPC_W)) u_judge (
    .ooo_ipc_i   (ooo_ipc_i),
    .static_ipc_i(static_ipc_i),
    .ok_o        (ipc_ok)
  );

  msw_lane_ctrl #(.NUM_LANES(NUM_LANES), .OOO_LANES(OOO_LANES)) u_lane (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lane_nxt_i(lane_d),
    .lane_cnt_o(lane_cnt),
    .lane_en_o (lane_en_o)
  );

  always_comb begin
    mode_d = mode_q;
    cur_d  = cur_q;
    nv_d   = nv_q;
    nid_d  = nid_q;
    nw_d   = nw_q;
    lane_d = lane_cnt;
    evt_d  = evt_id_o;
    dem_d  = 1'b0;
    pro_d  = 1'b0;
    rs_d   = 1'b0;
    if (rb) begin
      mode_d = MODE_OOO;
      nv_d   = 1'b0;
      lane_d = WIDTH_W'(OOO_LANES);
      dem_d  = 1'b1;
      evt_d  = cur_q;
      rs_d   = 1'b1;
    end else if (!in_static) begin
      if (accept) begin
        mode_d = MODE_STATIC;
        cur_d  = lookup_id_i;
        lane_d = acc_w;
      end
    end else if (done) begin
      evt_d = cur_q;
      pro_d = ipc_ok;
      dem_d = !ipc_ok;
      if (nv_q) begin
        // queued frame takes over; narrowing allowed now
        cur_d  = nid_q;
        lane_d = nw_q;
        nv_d   = 1'b0;
        if (accept) begin
          nv_d  = 1'b1;
          nid_d = lookup_id_i;
          nw_d  = acc_w;
          if (acc_w > nw_q) lane_d = acc_w;
        end
      end else if (accept) begin
        cur_d  = lookup_id_i;
        lane_d = acc_w;
      end else begin
        mode_d = MODE_OOO;
        lane_d = WIDTH_W'(OOO_LANES);
      end
    end else if (accept) begin
      nv_d  = 1'b1;
      nid_d = lookup_id_i;
      nw_d  = acc_w;
      if (acc_w > lane_cnt) lane_d = acc_w;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_OOO;
      cur_q     <= '0;
      nv_q      <= 1'b0;
      nid_q     <= '0;
      nw_q      <= '0;
      evt_id_o  <= '0;
      demote_o  <= 1'b0;
      promote_o <= 1'b0;
      restart_o <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      cur_q     <= cur_d;
      nv_q      <= nv_d;
      nid_q     <= nid_d;
      nw_q      <= nw_d;
      evt_id_o  <= evt_d;
      demote_o  <= dem_d;
      promote_o <= pro_d;
      restart_o <= rs_d;
    end
  end

  assign static_mode_o = in_static;
endmodule

// File: rtl/msw_chk.sv
module msw_chk #(
  parameter int NUM_LANES = 6,
  parameter int OOO_LANES = 4,
  parameter int ROB_DEPTH = 128,
  parameter int MIN_OPS   = 64,
  parameter int OPS_W     = 9,
  localparam int ROB_W    = $clog2(ROB_DEPTH + 1)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 lookup_valid_i,
  input logic                 lookup_present_i,
  input logic                 lookup_friendly_i,
  input logic                 lookup_trained_i,
  input logic [OPS_W-1:0]     lookup_ops_i,
  input logic [ROB_W-1:0]     rob_occ_i,
  input logic                 frame_done_i,
  input logic                 ctrl_mismatch_i,
  input logic                 mem_conflict_i,
  input logic                 exception_i,
  input logic                 static_mode_o,
  input logic [NUM_LANES-1:0] lane_en_o,
  input logic                 demote_o,
  input logic                 promote_o,
  input logic                 restart_o
);
  logic rb_any;
  assign rb_any = ctrl_mismatch_i || mem_conflict_i || exception_i;

  // R1
  unfriendly_refused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !static_mode_o && lookup_valid_i && lookup_trained_i && !lookup_friendly_i |=> !static_mode_o);

  // R2
  rob_full_refused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !static_mode_o && lookup_valid_i && (2 * int'(rob_occ_i) > ROB_DEPTH) |=> !static_mode_o);

  // R3
  small_frame_refused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !static_mode_o && lookup_valid_i && (int'(lookup_ops_i) < MIN_OPS) |=> !static_mode_o);

  // R6
  rollback_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    static_mode_o && rb_any |=> !static_mode_o && demote_o && restart_o && !promote_o);

  // R5
  one_verdict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(demote_o && promote_o));

  // R8
  no_early_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    static_mode_o && !frame_done_i && !rb_any |=>
      $countones(lane_en_o) >= $countones($past(lane_en_o)));

  // R9
  ooo_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(static_mode_o) |-> $countones(lane_en_o) == OOO_LANES);

  // R10
  lane_contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_en_o[0] && ((lane_en_o & (lane_en_o + 1'b1)) == '0));
endmodule

bind mode_switch_ctrl msw_chk #(
  .NUM_LANES(NUM_LANES), .OOO_LANES(OOO_LANES), .ROB_DEPTH(ROB_DEPTH),
  .MIN_OPS(MIN_OPS), .OPS_W(OPS_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .lookup_valid_i(lookup_valid_i), .lookup_present_i(lookup_present_i),
  .lookup_friendly_i(lookup_friendly_i), .lookup_trained_i(lookup_trained_i),
  .lookup_ops_i(lookup_ops_i), .rob_occ_i(rob_occ_i), .frame_done_i(frame_done_i),
  .ctrl_mismatch_i(ctrl_mismatch_i), .mem_conflict_i(mem_conflict_i),
  .exception_i(exception_i), .static_mode_o(static_mode_o), .lane_en_o(lane_en_o),
  .demote_o(demote_o), .promote_o(promote_o), .restart_o(restart_o)
);

// File: tb/sim_mode_switch_ctrl.sv
module sim_mode_switch_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lk_v = 0, lk_p = 0, lk_f = 0, lk_t = 0;
  logic [3:0] lk_id = 0;
  logic [8:0] lk_ops = 0;
  logic [2:0] lk_w = 0;
  logic [7:0] rob = 0;
  logic       done = 0;
  logic [7:0] oipc = 0, sipc = 0;
  logic       cm = 0, mc = 0, ex = 0;
  logic       st_o, dem_o, pro_o, rs_o;
  logic [5:0] lane_o;
  logic [3:0] id_o;

  int n_cmp = 0, n_bad = 0;
  string req = "R11";
  bit finished = 0;

  // reference model state
  int m_st, m_lane, m_cur, m_nv, m_nid, m_nw, m_dem, m_pro, m_rs, m_id;

  always #2.5 clk = ~clk;

  mode_switch_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .lookup_valid_i(lk_v), .lookup_present_i(lk_p), .lookup_friendly_i(lk_f),
    .lookup_trained_i(lk_t), .lookup_id_i(lk_id), .lookup_ops_i(lk_ops),
    .lookup_width_i(lk_w), .rob_occ_i(rob), .frame_done_i(done),
    .ooo_ipc_i(oipc), .static_ipc_i(sipc),
    .ctrl_mismatch_i(cm), .mem_conflict_i(mc), .exception_i(ex),
    .static_mode_o(st_o), .lane_en_o(lane_o), .demote_o(dem_o),
    .promote_o(pro_o), .evt_id_o(id_o), .restart_o(rs_o)
  );

  task automatic model_reset();
    m_st = 0; m_lane = 4; m_cur = 0; m_nv = 0; m_nid = 0; m_nw = 0;
    m_dem = 0; m_pro = 0; m_rs = 0; m_id = 0;
  endtask

  task automatic model_step();
    int w;
    bit acc;
    m_dem = 0; m_pro = 0; m_rs = 0;
    w = (lk_w == 0) ? 1 : (lk_w > 6) ? 6 : int'(lk_w);
    acc = lk_v && lk_p && (lk_f || !lk_t) && (2 * int'(rob) <= 128);
    if (m_st == 1 && (cm || mc || ex)) begin
      m_st = 0; m_lane = 4; m_nv = 0; m_dem = 1; m_id = m_cur; m_rs = 1;
    end else if (m_st == 0) begin
      if (acc && lk_ops >= 64) begin m_st = 1; m_cur = lk_id; m_lane = w; end
    end else if (done) begin
      m_id = m_cur;
      if (10 * int'(sipc) >= 9 * int'(oipc)) m_pro = 1; else m_dem = 1;
      if (m_nv == 1) begin
        m_cur = m_nid; m_lane = m_nw; m_nv = 0;
        if (acc) begin
          m_nv = 1; m_nid = lk_id; m_nw = w;
          if (w > m_lane) m_lane = w;
        end
      end else if (acc) begin
        m_cur = lk_id; m_lane = w;
      end else begin
        m_st = 0; m_lane = 4;
      end
    end else if (acc && m_nv == 0) begin
      m_nv = 1; m_nid = lk_id; m_nw = w;
      if (w > m_lane) m_lane = w;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  task automatic cmp(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cmp("mode", int'(st_o), m_st);
    cmp("lanes", int'(lane_o), (1 << m_lane) - 1);
    cmp("demote", int'(dem_o), m_dem);
    cmp("promote", int'(pro_o), m_pro);
    cmp("restart", int'(rs_o), m_rs);
    if (m_dem == 1 || m_pro == 1) cmp("evt_id", int'(id_o), m_id);
  endtask

  task automatic clr();
    lk_v = 0; lk_p = 0; lk_f = 0; lk_t = 0; lk_id = 0; lk_ops = 0; lk_w = 0;
    rob = 0; done = 0; cm = 0; mc = 0; ex = 0;
  endtask

  task automatic lookup(input int id, input int ops, input int w, input bit f,
                        input bit t, input bit p, input int occ);
    lk_v = 1; lk_p = p; lk_f = f; lk_t = t; lk_id = 4'(id);
    lk_ops = 9'(ops); lk_w = 3'(w); rob = 8'(occ);
  endtask

  task automatic step1();
    tick(); clr();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    int s;
    model_reset();
    clr();
    // R11: reset state
    req = "R11"; tick(); tick();
    rst_n = 1;
    tick();

    // R3: 63 ops refused, 64 accepted; R7: width 2 from OoO
    req = "R3"; lookup(1, 63, 2, 1, 1, 1, 10); step1(); step1();
    lookup(2, 64, 2, 1, 1, 1, 10); req = "R7"; step1(); step1();
    // R5: exact 90% promotes, R9: back to 4 lanes
    req = "R5"; done = 1; oipc = 10; sipc = 9; step1(); req = "R9"; step1(); step1();

    // R2: occupancy 65 refused, 64 accepted
    req = "R2"; lookup(3, 100, 3, 1, 1, 1, 65); step1(); step1();
    lookup(3, 100, 3, 1, 1, 1, 64); step1(); step1();
    // R1 in static: absent and unfriendly-trained refused for queueing
    req = "R1"; lookup(4, 10, 6, 1, 1, 0, 0); step1();
    lookup(5, 10, 6, 0, 1, 1, 0); step1(); step1();
    // R4/R7: queue untrained small frame, wider -> widen at once
    req = "R7"; lookup(6, 10, 5, 0, 0, 1, 0); step1();
    req = "R4"; lookup(7, 10, 6, 1, 1, 1, 0); step1(); step1();
    // R8: commit swaps in queued frame; queue narrow one, stays wide until commit
    req = "R8"; done = 1; oipc = 10; sipc = 8; step1();
    lookup(8, 5, 2, 1, 1, 1, 0); step1(); step1(); step1();
    done = 1; oipc = 20; sipc = 30; step1(); step1();
    // R4: commit and lookup in same cycle with empty slot
    req = "R4"; done = 1; oipc = 5; sipc = 5; lookup(9, 3, 3, 1, 1, 1, 0); step1(); step1();
    // R4: commit with full slot and lookup refill same cycle
    lookup(10, 3, 1, 1, 1, 1, 0); step1();
    done = 1; oipc = 5; sipc = 5; lookup(11, 3, 4, 1, 1, 1, 0); step1(); step1();
    done = 1; step1(); done = 1; step1(); step1();

    // R6: each rollback cause, including with queued frame and same-cycle commit
    req = "R6";
    for (int k = 0; k < 3; k++) begin
      lookup(12 + k, 80, 6, 1, 1, 1, 0); step1();
      lookup(1, 2, 2, 1, 1, 1, 0); step1();
      if (k == 0) cm = 1; else if (k == 1) mc = 1; else ex = 1;
      done = (k == 2); step1(); step1();
    end
    cm = 1; done = 1; step1(); step1();  // ignored in OoO

    // R7: clamps
    req = "R7"; lookup(3, 64, 7, 1, 1, 1, 0); step1();
    lookup(4, 1, 0, 1, 1, 1, 0); step1(); done = 1; step1(); step1();
    done = 1; step1(); step1();

    // R10 and all: random traffic
    req = "R10";
    s = 32'h1234_5678;
    for (int i = 0; i < 3000; i++) begin
      tick(); clr();
      s = s ^ (s << 13); s = s ^ (s >>> 17); s = s ^ (s << 5);
      if ((s & 3) == 0)
        lookup((s >>> 4) & 15, (s >>> 8) & 127, (s >>> 15) & 7,
               ((s >>> 18) & 3) != 0, (s >>> 20) & 1, ((s >>> 21) & 7) != 0,
               (s >>> 24) % 90);
      done = ((s >>> 2) & 7) == 0;
      oipc = 8'((s >>> 10) & 31); sipc = 8'((s >>> 25) & 31);
      cm = ((s >>> 27) & 31) == 0; mc = ((s >>> 5) & 63) == 1; ex = ((s >>> 11) & 63) == 2;
    end
    step1(); step1();
    finish_run();
  end
endmodule